// File: doc/BRIEF.md
# Prefix Instruction Stream Encoder

This block turns one instruction request into the byte stream that a prefix-based stack machine needs to execute it. A request carries a 4-bit function code and a 32-bit signed operand. The operand is rebuilt at run time from 4-bit nibbles. Each byte holds a function code in its upper nibble and an operand nibble in its lower nibble. Operands that do not fit one nibble are built up by a chain of prefix bytes (code 0x2) and negative-prefix bytes (code 0x6) placed ahead of the function byte.

The request side uses a valid/ready handshake. The output is a byte stream with its own valid/ready handshake and a last flag. The encoder computes the whole chain in the cycle it accepts a request. It then sends the chain one byte per accepted transfer, most significant step first. It takes no new request until the final byte has left.

Top module: `pfx_enc`

## Requirements
- R1: An operand v with 0 <= v <= 15 produces exactly one byte, {fn, v[3:0]}, and that byte has last set.
- R2: An operand v >= 16 is sent as the encoding of function 0x2 with operand v>>4, followed by the byte {fn, v[3:0]}. Each prefix byte has 0x2 in bits [7:4] and one operand nibble in bits [3:0], with the most significant nibble first.
- R3: An operand v < 0 is sent as the encoding of function 0x6 with operand (~v)>>4, followed by {fn, v[3:0]}. For example, -1 gives 0x60 and then {fn, 0xF}.
- R4: The number of bytes is the number that the rules in R1 to R3 produce, and it never exceeds 9.
- R5: Decoding the bytes in order rebuilds the requested 32-bit operand. Starting from a zero register, a 0x2 byte sets reg = (reg | nib) << 4, a 0x6 byte sets reg = ~(reg | nib) << 4, and the final byte yields reg | nib.
- R6: out_last_o is high on the final (function) byte and low on every prefix byte.
- R7: While out_valid_o is high and out_ready_i is low, out_byte_o and out_last_o stay unchanged and out_valid_o stays high.
- R8: req_ready_o is low from the cycle after a request is accepted until the final byte has been accepted. out_valid_o rises in the cycle after acceptance, and req_ready_o is high again in the cycle after the final byte is accepted.
- R9: After reset, out_valid_o is low and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Encoder idle; request can be taken |
| req_fn_i | input | 4 | Function code of the request |
| req_opd_i | input | 32 | Signed operand of the request |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream takes the byte |
| out_byte_o | output | 8 | Encoded byte |
| out_last_o | output | 1 | Marks the function byte that ends the sequence |

## Verification
The bench accepts a request on one rising edge and expects the first byte at the following falling edge, because one register stage holds the whole chain. Each byte after that is due one cycle after the previous one is taken. req_ready_o is expected back one cycle after the last transfer. The bench drives out_ready_i at random at each falling edge and samples the outputs at that same falling edge. It compares each transferred byte in order with a sequence built from the recursive rules, and it decodes the collected bytes back to the operand.

// File: rtl/pfx_enc_pkg.sv
package pfx_enc_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] FN_PFIX = 4'h2;
  localparam logic [NIB_W-1:0] FN_NFIX = 4'h6;
endpackage

// File: rtl/pfx_chain.sv
module pfx_chain
  import pfx_enc_pkg::*;
#(
  parameter int OPD_W = 32,
  parameter int MAX_B = OPD_W / NIB_W + 1,
  parameter int CNT_W = $clog2(MAX_B + 1)
) (
  input  logic [NIB_W-1:0]             fn_i,
  input  logic [OPD_W-1:0]             opd_i,
  output logic [MAX_B-1:0][BYTE_W-1:0] bytes_o,  // [0] = function byte
  output logic [CNT_W-1:0]             len_o
);
  localparam logic [OPD_W-1:0] NIB_SPAN = OPD_W'(1 << NIB_W);

  logic [OPD_W-1:0] v;
  logic [NIB_W-1:0] f;
  logic             done;

  // step k holds the byte emitted k positions before the end
  always_comb begin
    v     = opd_i;
    f     = fn_i;
    done  = 1'b0;
    len_o = '0;
    for (int k = 0; k < MAX_B; k++) begin
      bytes_o[k] = {f, v[NIB_W-1:0]};
      if (!done) begin
        len_o = CNT_W'(k + 1);
        if (!v[OPD_W-1] && (v < NIB_SPAN)) begin
          done = 1'b1;
        end else if (!v[OPD_W-1]) begin
          f = FN_PFIX;
          v = v >> NIB_W;
        end else begin
          f = FN_NFIX;
          v = (~v) >> NIB_W;
        end
      end
    end
  end
endmodule

// File: rtl/pfx_seq.sv
module pfx_seq
  import pfx_enc_pkg::*;
#(
  parameter int MAX_B = 9,
  parameter int CNT_W = $clog2(MAX_B + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [MAX_B-1:0][BYTE_W-1:0] bytes_i,
  input  logic [CNT_W-1:0]             len_i,
  input  logic                         out_ready_i,
  output logic                         busy_o,
  output logic                         out_valid_o,
  output logic [BYTE_W-1:0]            out_byte_o,
  output logic                         out_last_o
);
  logic [MAX_B-1:0][BYTE_W-1:0] buf_q;
  logic [CNT_W-1:0]             rem_q;
  logic [CNT_W-1:0]             idx;

  assign busy_o      = (rem_q != '0);
  assign out_valid_o = busy_o;
  assign idx         = busy_o ? rem_q - CNT_W'(1) : '0;
  assign out_byte_o  = buf_q[idx];
  assign out_last_o  = (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      buf_q <= bytes_i;
      rem_q <= len_i;
    end else if (out_valid_o && out_ready_i) begin
      rem_q <= rem_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pfx_enc.sv
module pfx_enc
  import pfx_enc_pkg::*;
#(
  parameter int OPD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [NIB_W-1:0]  req_fn_i,
  input  logic [OPD_W-1:0]  req_opd_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              out_last_o
);
  localparam int MAX_B = OPD_W / NIB_W + 1;
  localparam int CNT_W = $clog2(MAX_B + 1);

  logic [MAX_B-1:0][BYTE_W-1:0] chain;
  logic [CNT_W-1:0]             chain_len;
  logic                         busy;
  logic                         load;

  assign req_ready_o = !busy;
  assign load        = req_valid_i && req_ready_o;

  pfx_chain #(.OPD_W(OPD_W), .MAX_B(MAX_B), .CNT_W(CNT_W)) u_chain (
    .fn_i    (req_fn_i),
    .opd_i   (req_opd_i),
    .bytes_o (chain),
    .len_o   (chain_len)
  );

  pfx_seq #(.MAX_B(MAX_B), .CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .bytes_i     (chain),
    .len_i       (chain_len),
    .out_ready_i (out_ready_i),
    .busy_o      (busy),
    .out_valid_o (out_valid_o),
    .out_byte_o  (out_byte_o),
    .out_last_o  (out_last_o)
  );
endmodule

// File: rtl/pfx_enc_chk.sv
module pfx_enc_chk
  import pfx_enc_pkg::*;
#(
  parameter int OPD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [NIB_W-1:0]  req_fn_i,
  input logic [OPD_W-1:0]  req_opd_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [BYTE_W-1:0] out_byte_o,
  input logic              out_last_o
);
  localparam int MAX_B = OPD_W / NIB_W + 1;

  logic             acc, xfer;
  logic [NIB_W-1:0] fn_q;
  int unsigned      sent_q;

  assign acc  = req_valid_i && req_ready_o;
  assign xfer = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_q   <= '0;
      sent_q <= 0;
    end else if (acc) begin
      fn_q   <= req_fn_i;
      sent_q <= 0;
    end else if (xfer) begin
      sent_q <= out_last_o ? 0 : sent_q + 1;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_byte_o) && $stable(out_last_o)); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !req_ready_o); // R8
  AST_ACC_THEN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o); // R8
  AST_LAST_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer && out_last_o |=> req_ready_o); // R8
  AST_PREFIX_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_last_o |-> (out_byte_o[7:4] == FN_PFIX) || (out_byte_o[7:4] == FN_NFIX)); // R6
  AST_FINAL_FN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o |-> out_byte_o[7:4] == fn_q); // R6
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> sent_q < MAX_B); // R4
endmodule

bind pfx_enc pfx_enc_chk #(.OPD_W(OPD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_fn_i    (req_fn_i),
  .req_opd_i   (req_opd_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_byte_o  (out_byte_o),
  .out_last_o  (out_last_o)
);

// File: tb/pfx_enc_bench.sv
module pfx_enc_bench;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [3:0]  req_fn_i = '0;
  logic [31:0] req_opd_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [7:0]  out_byte_o;
  logic        out_last_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P / 2) clk_i = ~clk_i;

  pfx_enc u_pfx_enc (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected sequence from the recursive rules, in send order
  function automatic int build(input logic [3:0] fn, input logic [31:0] v, output logic [7:0] q[9]);
    logic [7:0]  tail[9];
    logic [3:0]  f = fn;
    logic [31:0] x = v;
    int n = 0;
    while (n < 9) begin
      tail[n] = {f, x[3:0]};
      n++;
      if ($signed(x) >= 0 && $signed(x) < 16) break;
      if ($signed(x) >= 16) begin f = 4'h2; x = x >> 4; end
      else begin f = 4'h6; x = (~x) >> 4; end
    end
    for (int i = 0; i < n; i++) q[i] = tail[n-1-i];
    return n;
  endfunction

  function automatic logic [31:0] decode(input logic [7:0] q[9], input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) begin
      if (i < n - 1 && q[i][7:4] == 4'h2) r = (r | 32'(q[i][3:0])) << 4;
      else if (i < n - 1 && q[i][7:4] == 4'h6) r = (~(r | 32'(q[i][3:0]))) << 4;
      else r = r | 32'(q[i][3:0]);
    end
    return r;
  endfunction

  task automatic run(input logic [3:0] fn, input logic [31:0] opd, input int stall_pct);
    logic [7:0] exp_q[9];
    logic [7:0] got[9];
    int n, idx;
    bit done, stalled, rdy;
    logic [7:0] pb;
    logic pl;
    string rq;
    n = build(fn, opd, exp_q);
    rq = (n == 1) ? "R1" : ($signed(opd) < 0 ? "R3" : "R2");
    chk(req_ready_o, "R8 idle ready", longint'(req_ready_o), 1);
    req_valid_i = 1'b1; req_fn_i = fn; req_opd_i = opd;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_opd_i = $urandom;
    chk(out_valid_o, "R8 valid after accept", longint'(out_valid_o), 1);
    idx = 0; done = 0; stalled = 0; pb = '0; pl = 0;
    while (!done && idx < 10) begin
      if (!out_valid_o) begin
        chk(0, "R8 valid drop", 0, 1);
        done = 1;
      end else begin
        if (req_ready_o) chk(0, "R8 ready while busy", 1, 0);
        if (stalled) chk(out_byte_o == pb && out_last_o == pl, "R7 hold", longint'(out_byte_o), longint'(pb));
        rdy = ($urandom % 100) >= stall_pct;
        out_ready_i = rdy;
        if (rdy) begin
          if (idx < 9) begin
            got[idx] = out_byte_o;
            chk(out_byte_o == exp_q[idx], rq, longint'(out_byte_o), longint'(exp_q[idx]));
            chk(out_last_o == (idx == n - 1), "R6 last flag", longint'(out_last_o), longint'(idx == n - 1));
          end
          idx++;
          if (out_last_o) done = 1;
        end
        stalled = !rdy; pb = out_byte_o; pl = out_last_o;
        @(negedge clk_i);
      end
    end
    out_ready_i = 1'b0;
    chk(idx == n, "R4 length", longint'(idx), longint'(n));
    chk(req_ready_o && !out_valid_o, "R8 ready after last", longint'(req_ready_o), 1);
    if (idx == n) chk(decode(got, n) == opd, "R5 decode", longint'(decode(got, n)), longint'(opd));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(!out_valid_o, "R9 valid in reset", longint'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!out_valid_o && req_ready_o, "R9 after reset", longint'({out_valid_o, req_ready_o}), 1);
    // directed corners
    run(4'h4, 32'd0, 0);           // R1
    run(4'hD, 32'd15, 0);          // R1
    run(4'h4, 32'd16, 0);          // R2
    run(4'h7, 32'd255, 30);        // R2
    run(4'h8, 32'd256, 30);        // R2
    run(4'hA, 32'hFFFF_FFFF, 0);   // R3: 0x60, 0xAF
    run(4'h4, 32'hFFFF_FFF0, 30);  // R3
    run(4'h4, 32'hFFFF_FFEF, 30);  // R3
    run(4'hF, 32'hFFFF_FF00, 50);  // R3
    run(4'h0, 32'h7FFF_FFFF, 50);  // R4 longest positive
    run(4'hB, 32'h8000_0000, 50);  // R4 longest negative
    run(4'h9, 32'h1234_5678, 70);  // R2 with heavy stalls (R7)
    // random mix
    for (int t = 0; t < 300; t++) begin
      logic [31:0] v;
      v = $urandom >> ($urandom % 32);
      if ($urandom % 2) v = ~v;
      run(4'($urandom), v, int'($urandom % 60));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule